// File: doc/BRIEF.md
# SPI serial clock prescaler

This block derives the serial clock of an SPI master from a faster reference clock. It divides in two stages. A linear stage divides by `pre + 1`, for 1 to 16. A binary stage then divides by `2^post`, for 1 to 32768. Each time the two stages complete a period, the block emits a one-cycle strobe, `tick_o`, and toggles `sclk_o`. The shift engine uses the strobe to place its data edges.

While `run_i` is low, the block holds both counters at zero and keeps `sclk_o` at the idle level. During that time it loads `pre_i`, `post_i` and `idle_pol_i` into its working settings. When `run_i` rises, counting restarts from a known state. The working settings then stay frozen until `run_i` falls again, so a change to the inputs during a run cannot glitch the clock.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: In a cycle that follows an edge where `run_i` was low, `tick_o` is 0 and `sclk_o` equals the `idle_pol_i` value sampled at that edge.
- R2: With `post` = 0 and `pre` > 0, ticks come exactly `pre + 1` cycles apart, and no two ticks fall on adjacent cycles.
- R3: Number the clock edges that sample `run_i` high as n = 0, 1, 2 and so on. A tick occurs at edge n exactly when n mod (pre+1) = 0 and (n / (pre+1)) mod 2^post = 2^post − 1. The tick rate is therefore reference / (pre+1) / 2^post.
- R4: With `pre` = 0 and `post` = 0, `tick_o` is high on every cycle of a run.
- R5: `sclk_o` inverts on every cycle where `tick_o` is high. During a run it changes at no other time.
- R6: Dropping `run_i` and raising it again restarts the timing of R3 from n = 0.
- R7: Changes to `pre_i`, `post_i` or `idle_pol_i` while `run_i` is high have no effect until the next idle period.
- R8: After reset, `tick_o` and `sclk_o` are 0.
- R9: With `post` = 15, the first tick of a run comes at n = (pre+1)·32767, and the following ticks are (pre+1)·32768 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while a transfer runs; low clears and idles |
| pre_i | input | 4 | Linear divide setting, divides by value + 1 |
| post_i | input | 4 | Binary divide setting, divides by 2^value |
| idle_pol_i | input | 1 | Level of `sclk_o` while idle |
| tick_o | output | 1 | One-cycle strobe at each SCLK edge |
| sclk_o | output | 1 | Divided serial clock |

## Verification
The assertions assume that `run_i` is a clean synchronous level and that `idle_pol_i` is held steady for at least one edge before a run starts. They also assume that the settings the block captured while idle are the ones in force for the whole run. The stimulus changes all inputs only on the falling clock edge. It always leaves `run_i` low for several cycles between runs. It deliberately moves `pre_i`, `post_i` and `idle_pol_i` in the middle of a run, so that the frozen-settings assumption is exercised rather than simply avoided.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int unsigned PreW  = 4;
  localparam int unsigned PostW = 4;
  localparam int unsigned BinW  = (1 << PostW) - 1;

  typedef struct packed {
    logic [PreW-1:0]  pre;
    logic [PostW-1:0] post;
    logic             idle_pol;
  } presc_cfg_t;
endpackage

// File: rtl/presc_lin_stage.sv
module presc_lin_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         en_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == '0)     cnt_q <= div_i;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign en_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/presc_bin_stage.sv
module presc_bin_stage #(
  parameter int unsigned SW = 4,
  parameter int unsigned CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (sel_i > SW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PreW-1:0]  pre_i,
  input  logic [PostW-1:0] post_i,
  input  logic             idle_pol_i,
  output logic             tick_o,
  output logic             sclk_o
);
  presc_cfg_t cfg_q;
  logic       lin_en, bin_hit;
  logic       tick_q, sclk_q;

  // settings load only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (!run_i) cfg_q <= '{pre: pre_i, post: post_i, idle_pol: idle_pol_i};
  end

  presc_lin_stage #(.W(PreW)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .div_i  (cfg_q.pre),
    .en_o   (lin_en)
  );

  presc_bin_stage #(.SW(PostW), .CW(BinW)) u_bin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .en_i   (lin_en),
    .sel_i  (cfg_q.post),
    .hit_o  (bin_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      tick_q <= 1'b0;
      sclk_q <= idle_pol_i;
    end else begin
      tick_q <= bin_hit;
      if (bin_hit) sclk_q <= ~sclk_q;
    end
  end

  assign tick_o = tick_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_presc_checker.sv
module spi_presc_checker
  import spi_presc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             idle_pol_i,
  input logic             tick_o,
  input logic             sclk_o,
  input logic [PreW-1:0]  cfg_pre,
  input logic [PostW-1:0] cfg_post
);
  a_r1_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (!tick_o && sclk_o == $past(idle_pol_i)));

  a_r5_edge_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> (tick_o || !$past(run_i)));

  a_r5_tick_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sclk_o != $past(sclk_o)));

  a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> ($stable(cfg_pre) && $stable(cfg_post)));

  a_r4_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && $past(cfg_pre) == '0 && $past(cfg_post) == '0) |-> tick_o);

  a_r2_no_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cfg_pre != '0) |=> !tick_o);
endmodule

bind spi_sclk_prescaler spi_presc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .idle_pol_i (idle_pol_i),
  .tick_o     (tick_o),
  .sclk_o     (sclk_o),
  .cfg_pre    (cfg_q.pre),
  .cfg_post   (cfg_q.post)
);

// File: tb/spi_sclk_prescaler_bench.sv
module spi_sclk_prescaler_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [3:0] pre_i = '0;
  logic [3:0] post_i = '0;
  logic       idle_pol_i = 1'b0;
  logic       tick_o, sclk_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R8";

  // reference model state
  int  m_n = 0, m_pre = 0, m_post = 0;
  bit  m_tick = 0, m_sclk = 0;

  always #2.5 clk_i = ~clk_i;

  spi_sclk_prescaler u_spi_sclk_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .pre_i(pre_i),
    .post_i(post_i), .idle_pol_i(idle_pol_i), .tick_o(tick_o), .sclk_o(sclk_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (!rst_ni) begin
      m_n = 0; m_tick = 0; m_sclk = 0;
    end else if (!run_i) begin
      m_pre = int'(pre_i); m_post = int'(post_i);
      m_n = 0; m_tick = 0; m_sclk = idle_pol_i;
    end else begin
      int per, q;
      per = m_pre + 1;
      q = 1 << m_post;
      m_tick = (m_n % per == 0) && ((m_n / per) % q == q - 1);
      if (m_tick) m_sclk = ~m_sclk;
      m_n++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      tests++;
      if (tick_o !== m_tick || sclk_o !== m_sclk) begin
        fails++;
        $display("FAIL %s cycle %0d: tick=%b sclk=%b expected tick=%b sclk=%b",
                 cur_req, cyc, tick_o, sclk_o, m_tick, m_sclk);
      end
    end
  end

  always @(posedge clk_i) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic do_run(input string req, input int p, input int q, input bit pol, input int len);
    @(negedge clk_i);
    cur_req = req;
    run_i = 1'b0; pre_i = 4'(p); post_i = 4'(q); idle_pol_i = pol;
    repeat (3) @(negedge clk_i);
    run_i = 1'b1;
    repeat (len) @(negedge clk_i);
    run_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    // R8: reset state
    #1;
    tests++;
    if (tick_o !== 1'b0 || sclk_o !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: tick=%b sclk=%b expected 0 0", tick_o, sclk_o);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    do_run("R4", 0, 0, 1'b0, 20);
    do_run("R2", 2, 0, 1'b0, 30);
    do_run("R2", 15, 0, 1'b1, 70);
    do_run("R3", 1, 3, 1'b0, 120);
    do_run("R3", 3, 2, 1'b1, 150);
    do_run("R1", 0, 1, 1'b1, 10);
    do_run("R1", 0, 1, 1'b0, 10);
    // R6: interrupt a run then restart with the same settings
    do_run("R6", 2, 2, 1'b0, 17);
    do_run("R6", 2, 2, 1'b0, 40);
    // R7: settings moved mid-run are ignored
    @(negedge clk_i);
    cur_req = "R7";
    run_i = 1'b0; pre_i = 4'd1; post_i = 4'd1; idle_pol_i = 1'b0;
    repeat (3) @(negedge clk_i);
    run_i = 1'b1;
    repeat (5) @(negedge clk_i);
    pre_i = 4'd7; post_i = 4'd4; idle_pol_i = 1'b1;
    repeat (40) @(negedge clk_i);
    run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    do_run("R9", 0, 15, 1'b0, 33000);
    do_run("R3", 15, 2, 1'b0, 200);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule